// File: doc/BRIEF.md
# Line Timing Ancillary Packet Generator

This block turns per-line encoder timing state into one short ancillary packet on an 8-bit byte stream. A downstream video encoder reads the packet to lock its own line and colour-subcarrier timing. The packet carries the field identity, the colour phase sign and two phase-accumulator increments. A line-start pulse, qualified by an enable, captures all payload inputs into holding registers. The block then presents the packet one word at a time on a valid/ready output.

Every payload word holds at most six information bits. Bit 6 carries even parity over bits 5..0 and bit 7 is its inverse, so no payload word can look like a timing code. The packet ends with a 7-bit running sum of the protected words, and carries out of bit 6 are dropped. With the consumer always ready, the packet takes a fixed number of cycles. The surrounding line scheduler can therefore place the line-start pulse early enough that the packet finishes before the start-of-active-video code.

Back-pressure rules: a word is transferred on every cycle in which `pkt_valid_o` and `pkt_ready_i` are both high. While valid is high and ready is low, the block holds the word and keeps valid high. Valid never drops before the last word is transferred. `pkt_ready_i` has no effect on the outputs in the cycle it is applied.

Top module: `anc_pkt_gen`

## Requirements
- R1: While reset is asserted and immediately after it, `pkt_valid_o` and `pkt_done_o` are low.
- R2: A line-start pulse is accepted only when `enable_i` is high and no packet is in progress. A pulse with enable low, or a pulse during a packet, leaves the output stream unchanged.
- R3: Each packet opens with the words 0x00, 0xFF, 0xFF, in that order.
- R4: The next three words are the packet identifier (payload 0x15 at default parameters), the block number (payload 0x01) and the user word count (payload 11 at default widths).
- R5: In every header and user word, bit 6 equals the XOR of bits 5..0 and bit 7 is the inverse of bit 6.
- R6: User word 0 carries the phase sign in bit 5, field bit 2 in bit 4 and field bit 1 in bit 3, with bits 2..0 zero. The phase sign is forced to 0 when `pal_mode_i` is low.
- R7: User words 1 and 2 carry `hinc_i[7:4]` and then `hinc_i[3:0]` in bits 3..0, with bits 5..4 zero.
- R8: User words 3 to 10 carry `scinc_i` four bits at a time, most significant nibble first, in bits 3..0, with bits 5..4 zero.
- R9: The last word holds, in bits 6..0, the sum modulo 128 of bits 6..0 of words 3 through 16. Its bit 7 is the inverse of its bit 6.
- R10: The payload is sampled on the accepted line-start edge. Input changes during a packet do not alter the words sent.
- R11: While valid is high and ready is low, the word and valid are held. With ready held high, the 18 words appear on 18 consecutive cycles, the first in the cycle after the line-start edge.
- R12: `pkt_done_o` is high for exactly one cycle, the cycle after the last word is transferred, and valid is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Enables packet generation |
| line_start_i | input | 1 | Per-line start pulse |
| pal_mode_i | input | 1 | High for PAL coding, low for NTSC coding (phase sign forced 0) |
| field2_i | input | 1 | Field bit 2 |
| field1_i | input | 1 | Field bit 1 |
| v_sign_i | input | 1 | Sign of V on this line (1 = positive) |
| hinc_i | input | HINC_W (8) | Horizontal PLL increment |
| scinc_i | input | SCINC_W (32) | Subcarrier PLL increment |
| pkt_data_o | output | 8 | Packet word |
| pkt_valid_o | output | 1 | Word valid |
| pkt_ready_i | input | 1 | Consumer ready |
| pkt_done_o | output | 1 | One-cycle pulse after the last word |

## Verification
The bench sweeps all sixteen combinations of mode, phase sign and the two field bits. Each combination is paired with several increment values, including all-zero and all-one, and every word is compared with a value computed arithmetically. The mode sweep shows whether the phase sign is forced correctly, and the increment values show whether nibble order or checksum carry handling is wrong. Packets alternate between a consumer that is always ready, which tests cycle count and latency, and pseudo-random stalls, which test word holding. Some packets change the inputs and pulse a second line-start while a packet is in progress, and a pulse is also sent with enable low. Together these show that capture takes place only on an accepted start.

// File: rtl/anc_pkt_pkg.sv
package anc_pkt_pkg;
  localparam int PRE_LEN    = 3;
  localparam int HDR_LEN    = 3;
  localparam int FIRST_USER = PRE_LEN + HDR_LEN;
  localparam int FIRST_SUM  = PRE_LEN;

  // Header/user word: six info bits, bit 6 even parity, bit 7 its inverse (R5)
  function automatic logic [7:0] prot_word(input logic [5:0] p);
    logic par;
    par = ^p;
    return {~par, par, p};
  endfunction

  // Checksum word: 7-bit sum, bit 7 inverse of bit 6 (R9)
  function automatic logic [7:0] close_word(input logic [6:0] s);
    return {~s[6], s};
  endfunction
endpackage

// File: rtl/anc_seq.sv
module anc_seq #(
  parameter int N_WORDS = 18,
  localparam int IDX_W = $clog2(N_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             busy_o,
  output logic             capture_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             last;

  assign last      = (idx_q == IDX_W'(N_WORDS - 1));
  assign capture_o = start_i & ~busy_q;   // R2: starts ignored while busy
  assign accept_o  = busy_q & ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= accept_o & last;          // R12
      if (capture_o) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (accept_o) begin
        if (last) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;
endmodule

// File: rtl/anc_payload.sv
module anc_payload #(
  parameter int HINC_W  = 8,
  parameter int SCINC_W = 32,
  localparam int HN     = HINC_W / 4,
  localparam int SN     = SCINC_W / 4,
  localparam int N_USER = 1 + HN + SN,
  localparam int UIDX_W = $clog2(N_USER)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              pal_mode_i,
  input  logic              field2_i,
  input  logic              field1_i,
  input  logic              v_sign_i,
  input  logic [HINC_W-1:0] hinc_i,
  input  logic [SCINC_W-1:0] scinc_i,
  input  logic [UIDX_W-1:0] sel_i,
  output logic [5:0]        word_o
);
  logic [5:0] fresh [N_USER];
  logic [5:0] held  [N_USER];

  // R6: sign bit forced low outside PAL mode
  assign fresh[0] = {pal_mode_i & v_sign_i, field2_i, field1_i, 3'b000};

  // R7: horizontal increment, high nibble first
  for (genvar g = 0; g < HN; g++) begin : g_hinc
    assign fresh[1 + g] = {2'b00, hinc_i[HINC_W - 1 - 4*g -: 4]};
  end

  // R8: subcarrier increment, most significant nibble first
  for (genvar g = 0; g < SN; g++) begin : g_scinc
    assign fresh[1 + HN + g] = {2'b00, scinc_i[SCINC_W - 1 - 4*g -: 4]};
  end

  // R10: payload captured only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_USER; k++) held[k] <= '0;
    end else if (capture_i) begin
      for (int k = 0; k < N_USER; k++) held[k] <= fresh[k];
    end
  end

  assign word_o = (int'(sel_i) < N_USER) ? held[sel_i] : 6'd0;
endmodule

// File: rtl/anc_crc_acc.sv
module anc_crc_acc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       add_i,
  input  logic [6:0] word_i,
  output logic [6:0] sum_o
);
  logic [6:0] sum_q;

  // R9: modulo-128 accumulation, carry out discarded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sum_q <= '0;
    else if (clear_i) sum_q <= '0;
    else if (add_i)   sum_q <= sum_q + word_i;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/anc_pkt_gen.sv
module anc_pkt_gen
  import anc_pkt_pkg::*;
#(
  parameter int         HINC_W    = 8,
  parameter int         SCINC_W   = 32,
  parameter logic [5:0] PKT_ID    = 6'h15,
  parameter logic [5:0] BLOCK_NUM = 6'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               line_start_i,
  input  logic               pal_mode_i,
  input  logic               field2_i,
  input  logic               field1_i,
  input  logic               v_sign_i,
  input  logic [HINC_W-1:0]  hinc_i,
  input  logic [SCINC_W-1:0] scinc_i,
  output logic [7:0]         pkt_data_o,
  output logic               pkt_valid_o,
  input  logic               pkt_ready_i,
  output logic               pkt_done_o
);
  localparam int N_USER  = 1 + HINC_W / 4 + SCINC_W / 4;
  localparam int N_WORDS = FIRST_USER + N_USER + 1;
  localparam int IDX_W   = $clog2(N_WORDS);
  localparam int UIDX_W  = $clog2(N_USER);

  logic             busy, capture, accept;
  logic [IDX_W-1:0] idx;
  logic [UIDX_W-1:0] usel;
  logic [5:0]       uword;
  logic [6:0]       sum;
  logic             sum_add;

  anc_seq #(.N_WORDS(N_WORDS)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (line_start_i & enable_i),
    .ready_i   (pkt_ready_i),
    .busy_o    (busy),
    .capture_o (capture),
    .accept_o  (accept),
    .idx_o     (idx),
    .done_o    (pkt_done_o)
  );

  assign usel = UIDX_W'(idx - IDX_W'(FIRST_USER));

  anc_payload #(.HINC_W(HINC_W), .SCINC_W(SCINC_W)) pay_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (capture),
    .pal_mode_i (pal_mode_i),
    .field2_i   (field2_i),
    .field1_i   (field1_i),
    .v_sign_i   (v_sign_i),
    .hinc_i     (hinc_i),
    .scinc_i    (scinc_i),
    .sel_i      (usel),
    .word_o     (uword)
  );

  assign sum_add = accept && (int'(idx) >= FIRST_SUM) && (int'(idx) <= N_WORDS - 2);

  anc_crc_acc crc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (capture),
    .add_i   (sum_add),
    .word_i  (pkt_data_o[6:0]),
    .sum_o   (sum)
  );

  // Word multiplexer: R3 preamble, R4 header, user words, R9 checksum
  always_comb begin
    if (int'(idx) == 0)                     pkt_data_o = 8'h00;
    else if (int'(idx) < PRE_LEN)           pkt_data_o = 8'hFF;
    else if (int'(idx) == PRE_LEN)          pkt_data_o = prot_word(PKT_ID);
    else if (int'(idx) == PRE_LEN + 1)      pkt_data_o = prot_word(BLOCK_NUM);
    else if (int'(idx) == PRE_LEN + 2)      pkt_data_o = prot_word(6'(N_USER));
    else if (int'(idx) < N_WORDS - 1)       pkt_data_o = prot_word(uword);
    else                                    pkt_data_o = close_word(sum);
  end

  assign pkt_valid_o = busy;   // R11: valid held until transfer
endmodule

// File: rtl/anc_pkt_gen_chk.sv
module anc_pkt_gen_chk #(
  parameter int N_WORDS = 18
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable_i,
  input logic       line_start_i,
  input logic [7:0] pkt_data_o,
  input logic       pkt_valid_o,
  input logic       pkt_ready_i,
  input logic       pkt_done_o
);
  localparam int CW = $clog2(N_WORDS);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (pkt_valid_o && pkt_ready_i)
      cnt <= (int'(cnt) == N_WORDS - 1) ? '0 : cnt + 1'b1;
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_valid_o && !(line_start_i && enable_i)) |=> !pkt_valid_o);

  assert_first_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid_o) |-> (pkt_data_o == 8'h00));

  assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o && int'(cnt) >= 3 && int'(cnt) <= N_WORDS - 2) |->
    ((pkt_data_o[6] == ^pkt_data_o[5:0]) && (pkt_data_o[7] != pkt_data_o[6])));

  assert_sum_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o && int'(cnt) == N_WORDS - 1) |-> (pkt_data_o[7] != pkt_data_o[6]));

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o)));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done_o |=> !pkt_done_o);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done_o |-> !pkt_valid_o);
endmodule

bind anc_pkt_gen anc_pkt_gen_chk #(.N_WORDS(N_WORDS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable_i     (enable_i),
  .line_start_i (line_start_i),
  .pkt_data_o   (pkt_data_o),
  .pkt_valid_o  (pkt_valid_o),
  .pkt_ready_i  (pkt_ready_i),
  .pkt_done_o   (pkt_done_o)
);

// File: tb/anc_pkt_gen_tb_top.sv
module anc_pkt_gen_tb_top;
  localparam int NW = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b0, line_start_i = 1'b0, pal_mode_i = 1'b0;
  logic        field2_i = 1'b0, field1_i = 1'b0, v_sign_i = 1'b0;
  logic [7:0]  hinc_i = '0;
  logic [31:0] scinc_i = '0;
  logic [7:0]  pkt_data_o;
  logic        pkt_valid_o, pkt_ready_i = 1'b0, pkt_done_o;

  int vectors = 0;
  int fails = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  exp_w [NW];

  always #5 clk = ~clk;

  anc_pkt_gen dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pw(input logic [5:0] p);
    return {~(^p), ^p, p};
  endfunction

  task automatic build(input logic pal, vs, f2, f1, input logic [7:0] hv, input logic [31:0] sv);
    logic [6:0] s;
    exp_w[0] = 8'h00; exp_w[1] = 8'hFF; exp_w[2] = 8'hFF;
    exp_w[3] = pw(6'h15); exp_w[4] = pw(6'h01); exp_w[5] = pw(6'd11);
    exp_w[6] = pw({pal & vs, f2, f1, 3'b000});
    exp_w[7] = pw({2'b00, hv[7:4]});
    exp_w[8] = pw({2'b00, hv[3:0]});
    for (int k = 0; k < 8; k++) exp_w[9 + k] = pw({2'b00, sv[31 - 4*k -: 4]});
    s = '0;
    for (int k = 3; k <= 16; k++) s = s + exp_w[k][6:0];
    exp_w[17] = {~s[6], s};
  endtask

  function automatic string tag_of(input int i);
    if (i < 3)  return "R3 preamble";
    if (i < 6)  return "R4 header";
    if (i == 6) return "R6 flags";
    if (i < 9)  return "R7 hinc";
    if (i < 17) return "R8 scinc";
    return "R9 checksum";
  endfunction

  task automatic run_packet(input logic pal, vs, f2, f1, input logic [7:0] hv,
                            input logic [31:0] sv, input bit bp, input bit perturb);
    int i, cyc;
    bit stall, rdy;
    logic [7:0] prev;
    build(pal, vs, f2, f1, hv, sv);
    @(negedge clk);
    pal_mode_i = pal; v_sign_i = vs; field2_i = f2; field1_i = f1;
    hinc_i = hv; scinc_i = sv; enable_i = 1'b1; line_start_i = 1'b1; pkt_ready_i = 1'b0;
    @(negedge clk);
    line_start_i = 1'b0;
    i = 0; cyc = 0; stall = 0; prev = '0;
    while (i < NW && cyc < 400) begin
      if (perturb && cyc == 2) begin
        // R10 / R2: change payload and re-pulse start mid-packet
        hinc_i = ~hv; scinc_i = ~sv; field1_i = ~f1; field2_i = ~f2;
        v_sign_i = ~vs; pal_mode_i = ~pal; line_start_i = 1'b1;
      end else begin
        line_start_i = 1'b0;
      end
      rdy = bp ? (lfsr[0] | lfsr[2]) : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pkt_ready_i = rdy;
      if (stall) chk(pkt_valid_o && pkt_data_o == prev, "R11 hold", {23'd0, pkt_valid_o, pkt_data_o}, {24'd1, prev});
      if (!bp) chk(pkt_valid_o, "R11 no gaps", 32'(pkt_valid_o), 32'd1);
      if (pkt_valid_o && rdy) begin
        chk(pkt_data_o == exp_w[i], perturb ? {tag_of(i), " R10"} : tag_of(i), 32'(pkt_data_o), 32'(exp_w[i]));
        if (i >= 3 && i <= 16)
          chk(pkt_data_o[6] == ^pkt_data_o[5:0] && pkt_data_o[7] == ~pkt_data_o[6], "R5 parity", 32'(pkt_data_o), 32'(exp_w[i]));
        i++;
      end
      stall = pkt_valid_o && !rdy;
      prev = pkt_data_o;
      cyc++;
      @(negedge clk);
    end
    pkt_ready_i = 1'b0; line_start_i = 1'b0;
    chk(i == NW, "R11 word count", 32'(i), 32'(NW));
    chk(pkt_done_o && !pkt_valid_o, "R12 done pulse", {30'd0, pkt_done_o, pkt_valid_o}, 32'd2);
    if (!bp) chk(cyc == NW, "R11 latency", 32'(cyc), 32'(NW));
    @(negedge clk);
    chk(!pkt_done_o && !pkt_valid_o, "R12 single pulse / R2 no restart", {30'd0, pkt_done_o, pkt_valid_o}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pkt_valid_o && !pkt_done_o, "R1 in reset", {30'd0, pkt_valid_o, pkt_done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pkt_valid_o && !pkt_done_o, "R1 after reset", {30'd0, pkt_valid_o, pkt_done_o}, 32'd0);

    // R2: start with enable low is ignored
    enable_i = 1'b0; line_start_i = 1'b1;
    @(negedge clk);
    line_start_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk(!pkt_valid_o, "R2 disabled start", 32'(pkt_valid_o), 32'd0);
      @(negedge clk);
    end

    for (int c = 0; c < 16; c++) begin
      for (int v = 0; v < 4; v++) begin
        logic [7:0]  hv;
        logic [31:0] sv;
        hv = 8'(c * 17 + v * 73 + 5);
        sv = 32'h9E3779B9 * 32'(c * 4 + v + 1);
        run_packet(c[3], c[2], c[1], c[0], hv, sv, v[0], v == 2);
      end
    end
    run_packet(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 32'h0, 1'b0, 1'b0);
    run_packet(1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 32'hFFFFFFFF, 1'b1, 1'b0);
    run_packet(1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 32'hFFFFFFFF, 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule